// File: doc/BRIEF.md
# Ratio Clock Divider Controller

This block turns one fast tick clock into seven related clock outputs: a host (CPU) clock, a memory clock, a peripheral-bus clock, a fixed 66 MHz class clock, a USB-rate clock, an interrupt-controller clock and a reference clock. Each output is a registered level produced from one shared phase counter. Time is counted in ticks, and a tick is half a master cycle, so a divide ratio `d` gives an output period of `2*d` ticks. With this scale a divide-by-1 output and a one-master-cycle high pulse can both be represented.

A two-bit mode select picks the rate table. One code parks the host, memory and peripheral outputs with their enables low. Two codes are normal host rates. The last is a test table of fixed ratios. A strap level is captured while reset is held and sets the interrupt-controller rate for the rest of the run. An active-low power-down input and a per-output mask stop outputs low. They do this only at an output's own falling edge and restart it only at its own rising edge, so no high pulse is ever cut short. A mode change is applied only at the common phase wrap, where every output is low.

Top module: `ratio_clk_div`

## Requirements
- R1: While `rstN` is low, every bit of `clkOut` is 0 and `clkOe` is 7'b1111000. Bit order of `clkOut`/`clkOe`: 0 host, 1 memory, 2 peripheral, 3 fixed-66, 4 USB, 5 interrupt controller, 6 reference.
- R2: Mode 2'b01 (low host rate): the divide ratios are host 3, memory 2, peripheral 6, fixed-66 3, USB 4, reference 12. In every 24 ticks each output therefore rises 12/d times.
- R3: Mode 2'b10 (high host rate) uses the same ratios as mode 01, except that the host divides by 2.
- R4: Mode 2'b00 drives `clkOe[2:0]` low and holds `clkOut[2:0]` low. Outputs 3 to 6 keep running with the mode-10 ratios.
- R5: Mode 2'b11 (test) uses the ratios host 2, memory 2, peripheral 6, fixed-66 3, USB 2, interrupt controller 6 and reference 1.
- R6: `strap` is sampled on every clock edge while `rstN` is low and held afterwards. Outside test mode the interrupt-controller ratio is 6 if the strap was 1 and 12 if it was 0. Changes on `strap` after reset have no effect.
- R7: A phase counter runs from 0 to 23 ticks. Every running output rises where the phase is a multiple of its period. An even ratio `d` is high for `d` ticks; an odd ratio above 1 is high for 2 ticks (one master cycle); ratio 1 is high for 1 tick.
- R8: A new `sel` value is taken only on the tick where the phase wraps from 23 to 0. The output pattern up to that tick follows the previous mode.
- R9: While `pdN` is low, each output finishes its current high pulse and then stays low. The phase counter parks at 23. On the first tick with `pdN` high again, every enabled and unmasked output rises.
- R10: Setting `outMask[i]` stops output i low at its next falling edge. Clearing the bit restarts the output at its next own rising edge. Every high pulse keeps its full R7 length.
- R11: After reset is released, the first clock edge wraps the phase to 0 and loads `sel`. All enabled, unmasked outputs rise on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the master rate |
| rstN | input | 1 | Synchronous active-low reset; strap capture window |
| sel | input | 2 | Rate table select |
| strap | input | 1 | Interrupt-controller rate strap |
| pdN | input | 1 | Active-low power-down |
| outMask | input | 7 | Per-output stop request |
| clkOut | output | 7 | Divided clock levels |
| clkOe | output | 7 | Output enables (0 = high impedance) |

## Verification
The bench goes after gating that acts mid-pulse. A design that stopped an output as soon as `pdN` fell or a mask bit rose would emit a high pulse shorter than its ratio allows, and the pulse-length monitor flags this. It also changes `sel` in the middle of a phase period; a design that applied the new table at once would show the new host pattern before the wrap. The strap is toggled after reset, and the interrupt-controller rate must not follow it. The bench also checks the first tick after a power-down ends: a design that did not realign its counters would bring the outputs back out of step instead of all rising together.

// File: rtl/rcd_pkg.sv
`timescale 1ns/1ps
package rcd_pkg;

  localparam int unsigned NUM_OUT  = 7;
  localparam int unsigned IDX_HOST = 0;
  localparam int unsigned IDX_MEM  = 1;
  localparam int unsigned IDX_PERI = 2;
  localparam int unsigned IDX_F66  = 3;
  localparam int unsigned IDX_USB  = 4;
  localparam int unsigned IDX_APIC = 5;
  localparam int unsigned IDX_REF  = 6;

  // Normal-mode ratios of the fixed outputs; they must divide BASE_LCM.
  localparam int unsigned DIV_USB  = 4;
  localparam int unsigned DIV_REF  = 12;
  localparam int unsigned BASE_LCM = 12;
  localparam int unsigned PH_LEN   = 2 * BASE_LCM;
  localparam int unsigned PH_W     = $clog2(PH_LEN);
  localparam logic [PH_W-1:0] PH_TOP = PH_W'(PH_LEN - 1);

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_LOW  = 2'b01,
    MODE_HIGH = 2'b10,
    MODE_TEST = 2'b11
  } mode_t;

  typedef struct packed {
    logic [PH_W-1:0] ph;
    logic [PH_W-1:0] phNext;
    mode_t           mode;
    mode_t           modeNext;
    logic            apicFull;
    logic            hold;
  } ctlStrobe_t;

  function automatic int unsigned divFor(mode_t m, int unsigned idx, logic apicFull);
    int unsigned d;
    d = 2;
    case (idx)
      IDX_HOST: d = (m == MODE_LOW) ? 3 : 2;
      IDX_MEM:  d = 2;
      IDX_PERI: d = 6;
      IDX_F66:  d = 3;
      IDX_USB:  d = (m == MODE_TEST) ? 2 : DIV_USB;
      IDX_APIC: d = (m == MODE_TEST || apicFull) ? 6 : 12;
      default:  d = (m == MODE_TEST) ? 1 : DIV_REF;
    endcase
    return d;
  endfunction

  function automatic logic levelAt(int unsigned d, logic [PH_W-1:0] ph);
    int unsigned pos;
    int unsigned hi;
    pos = int'(ph) % (2 * d);
    hi  = (d > 1 && (d % 2) == 1) ? 2 : d;
    return (pos < hi);
  endfunction

  function automatic logic oeFor(mode_t m, int unsigned idx);
    return !(m == MODE_OFF && idx <= IDX_PERI);
  endfunction

endpackage

// File: rtl/rcd_ctrl.sv
`timescale 1ns/1ps
module rcd_ctrl
  import rcd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] sel,
  input  logic       strap,
  input  logic       pdN,
  output ctlStrobe_t ctl
);

  logic [PH_W-1:0] phQ;
  logic [PH_W-1:0] phD;
  mode_t           modeQ;
  mode_t           modeD;
  logic            strapQ;
  logic            wrap;
  logic            hold;

  always_comb begin
    wrap  = (phQ == PH_TOP);
    hold  = !pdN && wrap;
    if (hold)      phD = phQ;
    else if (wrap) phD = '0;
    else           phD = phQ + PH_W'(1);
    modeD = (wrap && !hold) ? mode_t'(sel) : modeQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phQ    <= PH_TOP;
      modeQ  <= MODE_OFF;
      strapQ <= strap;
    end else begin
      phQ    <= phD;
      modeQ  <= modeD;
    end
  end

  always_comb begin
    ctl.ph       = phQ;
    ctl.phNext   = phD;
    ctl.mode     = modeQ;
    ctl.modeNext = modeD;
    ctl.apicFull = strapQ;
    ctl.hold     = hold;
  end

  // R8
  mode_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ != $past(modeQ)) |-> ($past(phQ) == PH_TOP));

  // R6
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(strapQ));

  // R7
  phase_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    phQ <= PH_TOP);

endmodule

// File: rtl/rcd_datapath.sv
`timescale 1ns/1ps
module rcd_datapath
  import rcd_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               pdN,
  input  logic [NUM_OUT-1:0] mask,
  input  ctlStrobe_t         ctl,
  output logic [NUM_OUT-1:0] clkOut,
  output logic [NUM_OUT-1:0] clkOe
);

  logic [NUM_OUT-1:0] outQ;
  logic [NUM_OUT-1:0] runQ;
  logic [NUM_OUT-1:0] oeQ;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    logic lvlNow;
    logic lvlNext;
    logic oeNext;
    logic want;
    logic runD;

    always_comb begin
      lvlNow  = levelAt(divFor(ctl.mode, i, ctl.apicFull), ctl.ph);
      lvlNext = levelAt(divFor(ctl.modeNext, i, ctl.apicFull), ctl.phNext);
      oeNext  = oeFor(ctl.modeNext, i);
      want    = pdN && !mask[i] && oeNext;
      runD    = runQ[i];
      if (runQ[i] && !want && !outQ[i])
        runD = 1'b0;
      else if (!runQ[i] && want && !lvlNow && lvlNext)
        runD = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        runQ[i] <= 1'b0;
        outQ[i] <= 1'b0;
        oeQ[i]  <= oeFor(MODE_OFF, i);
      end else begin
        runQ[i] <= runD;
        outQ[i] <= lvlNext && runD;
        oeQ[i]  <= oeNext;
      end
    end

    // R9
    pd_park_chk: assert property (@(posedge clk) disable iff (!rstN)
      ctl.hold |=> !outQ[i]);

    // R7
    rise_align_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(outQ[i]) |-> ((int'(ctl.ph) % (2 * divFor(ctl.mode, i, ctl.apicFull))) == 0));

    // R4
    off_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ctl.mode == MODE_OFF && i <= IDX_PERI) |-> (!oeQ[i] && !outQ[i]));
  end

  assign clkOut = outQ;
  assign clkOe  = oeQ;

endmodule

// File: rtl/ratio_clk_div.sv
`timescale 1ns/1ps
module ratio_clk_div
  import rcd_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         sel,
  input  logic               strap,
  input  logic               pdN,
  input  logic [NUM_OUT-1:0] outMask,
  output logic [NUM_OUT-1:0] clkOut,
  output logic [NUM_OUT-1:0] clkOe
);

  ctlStrobe_t ctl;

  rcd_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .sel   (sel),
    .strap (strap),
    .pdN   (pdN),
    .ctl   (ctl)
  );

  rcd_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .pdN    (pdN),
    .mask   (outMask),
    .ctl    (ctl),
    .clkOut (clkOut),
    .clkOe  (clkOe)
  );

endmodule

// File: tb/ratio_clk_div_test.sv
`timescale 1ns/1ps
module ratio_clk_div_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] sel = 2'b01;
  logic       strap = 1'b1;
  logic       pdN = 1'b1;
  logic [6:0] outMask = '0;
  logic [6:0] clkOut;
  logic [6:0] clkOe;

  int vecs = 0;
  int fails = 0;
  int cycles = 0;
  bit modelOn = 0;

  ratio_clk_div uut (
    .clk(clk), .rstN(rstN), .sel(sel), .strap(strap), .pdN(pdN),
    .outMask(outMask), .clkOut(clkOut), .clkOe(clkOe)
  );

  always #2.5 clk = ~clk;

  // ---------- bench functions from the requirements ----------
  function automatic int tbDiv(int m, int idx, bit full);
    case (idx)
      0: return (m == 1) ? 3 : 2;
      1: return 2;
      2: return 6;
      3: return 3;
      4: return (m == 3) ? 2 : 4;
      5: return (m == 3 || full) ? 6 : 12;
      default: return (m == 3) ? 1 : 12;
    endcase
  endfunction

  function automatic int tbHi(int d);
    if (d > 1 && (d % 2) == 1) return 2;
    return d;
  endfunction

  function automatic bit tbLvl(int d, int ph);
    return (ph % (2 * d)) < tbHi(d);
  endfunction

  function automatic bit tbOe(int m, int idx);
    return !(m == 0 && idx < 3);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------- cycle reference ----------
  int mPh, mMode;
  bit mStrap;
  bit [6:0] mRun, mOut, mOe;

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mPh = 23; mMode = 0; mStrap = strap; mRun = '0; mOut = '0;
      for (int i = 0; i < 7; i++) mOe[i] = tbOe(0, i);
    end else begin
      bit wrapB, holdB;
      int nPh, nMode;
      wrapB = (mPh == 23);
      holdB = !pdN && wrapB;
      nPh   = holdB ? mPh : (wrapB ? 0 : mPh + 1);
      nMode = (wrapB && !holdB) ? int'(sel) : mMode;
      for (int i = 0; i < 7; i++) begin
        bit cl, nl, oe, want;
        cl   = tbLvl(tbDiv(mMode, i, mStrap), mPh);
        nl   = tbLvl(tbDiv(nMode, i, mStrap), nPh);
        oe   = tbOe(nMode, i);
        want = pdN && !outMask[i] && oe;
        if (mRun[i] && !want && !mOut[i]) mRun[i] = 0;
        else if (!mRun[i] && want && !cl && nl) mRun[i] = 1;
        mOut[i] = nl && mRun[i];
        mOe[i]  = oe;
      end
      mPh = nPh; mMode = nMode;
    end
  end

  // ---------- per-tick compare and pulse-length monitor ----------
  int hiCnt [7];
  bit [6:0] prevOut = '0;

  always @(negedge clk) begin
    if (modelOn && rstN) begin
      chk(clkOut == mOut, "R7", "cycle clkOut", clkOut, mOut);
      chk(clkOe == mOe, "R4", "cycle clkOe", clkOe, mOe);
      for (int i = 0; i < 7; i++) begin
        if (clkOut[i]) hiCnt[i]++;
        else begin
          if (prevOut[i])
            chk(hiCnt[i] == tbHi(tbDiv(mMode, i, mStrap)), "R10",
                $sformatf("pulse length out%0d", i), hiCnt[i], tbHi(tbDiv(mMode, i, mStrap)));
          hiCnt[i] = 0;
        end
      end
    end else begin
      for (int i = 0; i < 7; i++) hiCnt[i] = 0;
    end
    prevOut = clkOut;
  end

  // ---------- stimulus helpers ----------
  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic countRises(int idx, int win, output int n);
    bit p;
    n = 0;
    p = clkOut[idx];
    repeat (win) begin
      @(negedge clk);
      if (clkOut[idx] && !p) n++;
      p = clkOut[idx];
    end
  endtask

  task automatic checkRates(int m, bit full, string req);
    for (int i = 0; i < 7; i++) begin
      int n;
      countRises(i, 24, n);
      chk(n == 12 / tbDiv(m, i, full), req, $sformatf("rises out%0d", i), n, 12 / tbDiv(m, i, full));
    end
  endtask

  task automatic doReset(bit s);
    strap = s; rstN = 0;
    tick(5);
    chk(clkOut == 7'h00, "R1", "reset clkOut", clkOut, 0);
    chk(clkOe == 7'b1111000, "R1", "reset clkOe", clkOe, 7'b1111000);
    rstN = 1;
    tick(1);
    chk(clkOut == 7'h7F, "R11", "first tick after reset", clkOut, 7'h7F);
  endtask

  // ---------- watchdog ----------
  initial begin
    wait (cycles > 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  // ---------- main sequence ----------
  initial begin
    int n;
    void'($urandom(32'd20240611));
    @(negedge clk);
    sel = 2'b01;
    modelOn = 1;
    doReset(1'b1);
    tick(30);
    checkRates(1, 1'b1, "R2");

    sel = 2'b10; tick(30);
    checkRates(2, 1'b1, "R3");

    sel = 2'b00; tick(30);
    chk(clkOe[2:0] == 3'b000, "R4", "enables off", clkOe[2:0], 0);
    for (int i = 0; i < 3; i++) begin
      countRises(i, 24, n);
      chk(n == 0, "R4", $sformatf("parked out%0d", i), n, 0);
    end
    countRises(3, 24, n);
    chk(n == 4, "R4", "fixed-66 still runs", n, 4);

    sel = 2'b11; tick(30);
    checkRates(3, 1'b1, "R5");

    sel = 2'b10; tick(30);
    outMask = 7'b0000001; tick(10);
    countRises(0, 24, n);
    chk(n == 0, "R10", "masked host", n, 0);
    countRises(1, 24, n);
    chk(n == 6, "R10", "unmasked memory", n, 6);
    outMask = '0; tick(30);
    countRises(0, 24, n);
    chk(n == 6, "R10", "host restarted", n, 6);

    pdN = 0; tick(40);
    countRises(0, 1, n);
    chk(clkOut == 7'h00, "R9", "parked low", clkOut, 0);
    for (int i = 0; i < 7; i++) begin
      countRises(i, 24, n);
      chk(n == 0, "R9", $sformatf("no edges out%0d", i), n, 0);
    end
    pdN = 1; tick(1);
    chk(clkOut == 7'h7F, "R9", "aligned restart", clkOut, 7'h7F);

    tick(30);
    while (mPh != 5) tick(1);
    sel = 2'b01;
    tick(1);
    chk(clkOut[0] == 1'b0, "R8", "old host pattern before wrap", clkOut[0], 0);
    while (mPh != 0) tick(1);
    while (mPh != 6) tick(1);
    chk(clkOut[0] == 1'b1, "R8", "new host pattern after wrap", clkOut[0], 1);

    for (int k = 0; k < 4000; k++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 2) sel = 2'($urandom);
      else if (r < 5) pdN = ~pdN;
      else if (r < 8) outMask = ($urandom % 3 == 0) ? 7'($urandom) : 7'h00;
      strap = 1'($urandom);
      tick(1);
    end
    pdN = 1; outMask = '0; sel = 2'b01;

    doReset(1'b0);
    strap = 1'b1;
    tick(30);
    countRises(5, 24, n);
    chk(n == 1, "R6", "apic at half peripheral rate", n, 1);
    countRises(2, 24, n);
    chk(n == 2, "R6", "peripheral rate", n, 2);
    sel = 2'b11; tick(30);
    countRises(5, 24, n);
    chk(n == 2, "R5", "apic in test mode", n, 2);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule